// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit effective address of one memory operand in a processor whose arithmetic instructions may name a memory operand directly. An operand address is built from up to three terms: a base register value, an index register value multiplied by 1, 2, 4 or 8, and a signed displacement. Each term carries its own enable, so one adder covers all the forms: base plus displacement, base plus index, scaled index, and scaled index plus displacement. A disabled term adds zero.

The displacement comes from the instruction stream. It is either a short 8-bit field, which is sign-extended, or a full 32-bit field. A mode input separates ordinary memory operands from address-only requests. For an address-only request the sum is sent to a destination register as data and no memory access takes place. The address and a destination flag are registered and appear one cycle after a valid request. Both hold their values while no request arrives.

Top module: `scaledAddrGen`

## Requirements
- R1: While `rstN` is low, `outValid`, `outAddr` and `outToReg` are all 0.
- R2: A request accepted with `inValid` high at a rising edge produces `outValid` high during the following cycle. Requests may be issued back to back, one per cycle, and results come out in issue order.
- R3: With only the base and displacement enabled, `outAddr` equals base plus the sign-extended displacement.
- R4: With base and index enabled, scale code 0 and the displacement disabled, `outAddr` equals base plus index.
- R5: The 2-bit `scaleSel` value is the left shift applied to the index: codes 0, 1, 2 and 3 multiply it by 1, 2, 4 and 8.
- R6: With all three terms enabled, `outAddr` equals base plus the shifted index plus the displacement.
- R7: When `dispWide` is 0, only `dispVal[7:0]` is used. It is sign-extended from bit 7, and `dispVal[31:8]` has no effect.
- R8: When `dispWide` is 1, all 32 bits of `dispVal` are added as given.
- R9: The sum is taken modulo 2^32, and carries out of bit 31 are dropped.
- R10: A term whose enable is 0 adds zero, whatever value sits on its data input.
- R11: `outToReg` is 1 for a request issued with `leaMode` high (the address goes to a register and no memory access is made). It is 0 for a memory operand.
- R12: While `inValid` is low, `outAddr` and `outToReg` keep their last values and `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A request is present this cycle |
| baseVal | input | 32 | Base register value |
| baseEn | input | 1 | Base term is used |
| idxVal | input | 32 | Index register value |
| idxEn | input | 1 | Index term is used |
| scaleSel | input | 2 | Left shift applied to the index (0 to 3) |
| dispVal | input | 32 | Displacement; only bits 7:0 when short |
| dispWide | input | 1 | 1: 32-bit displacement, 0: 8-bit sign-extended |
| dispEn | input | 1 | Displacement term is used |
| leaMode | input | 1 | 1: address-only request, result goes to a register |
| outValid | output | 1 | Result registers were loaded at the last edge |
| outAddr | output | 32 | Effective address |
| outToReg | output | 1 | 1: register destination, 0: memory access |

## Verification
The only state is one valid bit and the two result registers, so any fault in a strobe or a term shows up as a wrong `outAddr` or `outToReg` in the single cycle after the request that caused it. A bad valid register shows up in the same cycle, as a missing result, a spurious result or a shifted result. A result register that loads while idle shows up as a changed address during the gap between requests. The stimulus uses distinct bit patterns in every term, junk on disabled and ignored bits, every scale code, and a sum that crosses 2^32. Each of these faults therefore changes a value the bench compares.

// File: rtl/sagPkg.sv
package sagPkg;
  parameter int ADDR_W       = 32;
  parameter int SCALE_W      = 2;
  parameter int SHORT_DISP_W = 8;
  localparam int SCALE_N     = 1 << SCALE_W;

  typedef struct packed {
    logic               capture;   // load result registers
    logic               toReg;     // address-only request
    logic               useBase;
    logic               useIdx;
    logic               useDisp;
    logic               wideDisp;
    logic [SCALE_W-1:0] shamt;
  } sagStrobes_t;
endpackage

// File: rtl/sagCtrl.sv
module sagCtrl
  import sagPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               baseEn,
  input  logic               idxEn,
  input  logic               dispEn,
  input  logic               dispWide,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic               leaMode,
  output sagStrobes_t        strobes,
  output logic               outValid
);
  always_comb begin
    strobes.capture  = inValid;
    strobes.toReg    = leaMode;
    strobes.useBase  = baseEn;
    strobes.useIdx   = idxEn;
    strobes.useDisp  = dispEn;
    strobes.wideDisp = dispWide;
    strobes.shamt    = idxEn ? scaleSel : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: result valid exactly one cycle after the request
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/sagDatapath.sv
module sagDatapath
  import sagPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sagStrobes_t       strobes,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [ADDR_W-1:0] dispVal,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outToReg
);
  localparam int EXT_W = ADDR_W - SHORT_DISP_W;

  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] idxTerm;
  logic [ADDR_W-1:0] dispShort;
  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] scaledIdx;
  logic [ADDR_W-1:0] shiftCand [SCALE_N];
  logic [ADDR_W-1:0] sumNext;

  assign baseTerm  = strobes.useBase ? baseVal : '0;
  assign idxTerm   = strobes.useIdx  ? idxVal  : '0;
  assign dispShort = {{EXT_W{dispVal[SHORT_DISP_W-1]}}, dispVal[SHORT_DISP_W-1:0]};

  always_comb begin
    if (!strobes.useDisp)      dispTerm = '0;
    else if (strobes.wideDisp) dispTerm = dispVal;
    else                       dispTerm = dispShort;
  end

  for (genvar s = 0; s < SCALE_N; s++) begin : g_scale
    assign shiftCand[s] = idxTerm << s;
  end

  assign scaledIdx = shiftCand[strobes.shamt];
  assign sumNext   = baseTerm + scaledIdx + dispTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr  <= '0;
      outToReg <= 1'b0;
    end else if (strobes.capture) begin
      outAddr  <= sumNext;
      outToReg <= strobes.toReg;
    end
  end

  // R12: results are frozen while no request is presented
  p_hold_addr_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(outAddr) && $stable(outToReg));
  // R10: with every term disabled the loaded address is zero
  p_all_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.useBase && !strobes.useIdx && !strobes.useDisp)
      |=> outAddr == '0);
endmodule

// File: rtl/scaledAddrGen.sv
module scaledAddrGen
  import sagPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic               baseEn,
  input  logic [ADDR_W-1:0]  idxVal,
  input  logic               idxEn,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic               dispWide,
  input  logic               dispEn,
  input  logic               leaMode,
  output logic               outValid,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               outToReg
);
  sagStrobes_t strobes;

  sagCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .baseEn(baseEn), .idxEn(idxEn), .dispEn(dispEn), .dispWide(dispWide),
    .scaleSel(scaleSel), .leaMode(leaMode),
    .strobes(strobes), .outValid(outValid)
  );

  sagDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .baseVal(baseVal), .idxVal(idxVal), .dispVal(dispVal),
    .outAddr(outAddr), .outToReg(outToReg)
  );

  // R11: destination flag follows the mode of the request
  p_dest_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outToReg == $past(leaMode));
  // R1: reset clears the outputs
  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> !outValid && outAddr == '0 && !outToReg);
endmodule

// File: tb/scaledAddrGen_tb.sv
module scaledAddrGen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] baseVal = '0, idxVal = '0, dispVal = '0;
  logic        baseEn = 1'b0, idxEn = 1'b0, dispWide = 1'b0, dispEn = 1'b0, leaMode = 1'b0;
  logic [1:0]  scaleSel = '0;
  logic        outValid, outToReg;
  logic [31:0] outAddr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [31:0] expAddrQ[$];
  logic        expRegQ[$];
  int          expCycQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scaledAddrGen u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .baseVal(baseVal), .baseEn(baseEn), .idxVal(idxVal), .idxEn(idxEn),
    .scaleSel(scaleSel), .dispVal(dispVal), .dispWide(dispWide), .dispEn(dispEn),
    .leaMode(leaMode), .outValid(outValid), .outAddr(outAddr), .outToReg(outToReg)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] b, input bit bE, input logic [31:0] x,
      input bit xE, input logic [1:0] sc, input logic [31:0] d, input bit dW, input bit dE);
    logic [31:0] dx;
    logic [31:0] xs;
    dx = dW ? d : {{24{d[7]}}, d[7:0]};
    xs = xE ? (x << sc) : 32'h0;
    return (bE ? b : 32'h0) + xs + (dE ? dx : 32'h0);
  endfunction

  // driver: present one request for one cycle and record the expected result
  task automatic issue(input string tag, input logic [31:0] b, input bit bE, input logic [31:0] x,
      input bit xE, input logic [1:0] sc, input logic [31:0] d, input bit dW, input bit dE, input bit lea);
    baseVal = b; baseEn = bE; idxVal = x; idxEn = xE; scaleSel = sc;
    dispVal = d; dispWide = dW; dispEn = dE; leaMode = lea; inValid = 1'b1;
    expAddrQ.push_back(model(b, bE, x, xE, sc, d, dW, dE));
    expRegQ.push_back(lea);
    expCycQ.push_back(cyc + 1);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  // monitor: compare each produced result against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expAddrQ.size() == 0) begin
        check(1'b0, "R2 unexpected result", {31'h0, outValid}, 32'h0);
      end else begin
        logic [31:0] ea;
        logic er;
        int ec;
        string t;
        ea = expAddrQ.pop_front(); er = expRegQ.pop_front();
        ec = expCycQ.pop_front();  t  = tagQ.pop_front();
        check(outAddr == ea, t, outAddr, ea);
        check(outToReg == er, {t, " R11 dest"}, {31'h0, outToReg}, {31'h0, er});
        check(cyc == ec, {t, " R2 latency"}, cyc, ec);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outAddr == 32'h0 && outToReg == 1'b0, "R1 reset",
          {outValid, outToReg, outAddr[29:0]}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    issue("R3 R7 base+short neg disp", 32'h0000_1000, 1, 32'hDEAD_BEEF, 0, 2'd0, 32'h0000_00FC, 0, 1, 0);
    issue("R7 short disp upper bits ignored", 32'h0000_1000, 1, 32'h0, 0, 2'd0, 32'hABCD_EF05, 0, 1, 0);
    issue("R8 base+wide disp", 32'h2000_0000, 1, 32'h0, 0, 2'd0, 32'h0001_2345, 1, 1, 0);
    issue("R4 base+index", 32'h0000_0100, 1, 32'h0000_0023, 1, 2'd0, 32'h7777_7777, 1, 0, 0);
    for (int s = 0; s < 4; s++)
      issue("R5 scale code", 32'h0000_1000, 1, 32'h0000_0010, 1, 2'(s), 32'h0, 0, 0, 0);
    issue("R6 scaled index+disp", 32'h0000_4000, 1, 32'h0000_0003, 1, 2'd2, 32'h0000_0100, 1, 1, 0);
    issue("R9 wrap", 32'hFFFF_FFF0, 1, 32'h0000_0008, 1, 2'd1, 32'h0000_0001, 0, 1, 0);
    issue("R10 base disabled", 32'hFFFF_0000, 0, 32'h0000_0005, 1, 2'd3, 32'h0000_0020, 1, 1, 0);
    issue("R10 all disabled", 32'h1234_5678, 0, 32'h9ABC_DEF0, 0, 2'd3, 32'h5555_5555, 1, 0, 1);
    issue("R11 lea mode", 32'h0000_8000, 1, 32'h0000_0004, 1, 2'd2, 32'hFFFF_FFF8, 1, 1, 1);
    @(negedge clk);
    held = outAddr;
    // R12: junk on inputs with no request must leave outputs untouched
    baseVal = 32'hFFFF_FFFF; baseEn = 1; idxVal = 32'h1; idxEn = 1; leaMode = 0;
    repeat (3) @(negedge clk);
    check(outAddr == held, "R12 hold addr", outAddr, held);
    check(outToReg == 1'b1, "R12 hold dest", {31'h0, outToReg}, 32'h1);
    check(outValid == 1'b0, "R12 no valid while idle", {31'h0, outValid}, 32'h0);
    check(expAddrQ.size() == 0, "R2 results all produced", expAddrQ.size(), 32'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule